// File: doc/BRIEF.md
# Chip-Select Prefetch and Write-Posting Engine

This block moves a programmed number of bytes between a host and one byte-wide external device selected from up to eight chip selects. An internal byte FIFO sits between the two sides. In fetch-ahead (read) mode, the engine reads consecutive device addresses, starting at zero, into the FIFO while the host pops bytes out. In posting (write) mode, the host pushes bytes into the FIFO and the engine writes them to consecutive device addresses.

One engine is shared by all chip selects. A configuration word binds it to a single chip select. Configuration is locked while a transfer runs. A stop request is honoured only when it names the chip select that owns the engine. A request line, gated by a mode bit, tells a DMA agent when the FIFO holds enough data or enough free space. A status word gives the FIFO fill level, the remaining device transfers, the threshold condition and a completion flag.

The host register port has five word addresses: 0 config, 1 byte count, 2 run control, 3 status (read only) and 4 stop (write only). Register reads are combinational from `reg_addr`. Writes take effect at the clock edge.

Top module: `pfe_engine`

## Requirements
- R1: After reset the run-control register (address 2) reads 0, the status word (address 3) reads 0, `dma_req` is low and no device access occurs. The config word (address 0) reads the default threshold 64 in bits [14:8], which is 0x0000_4000.
- R2: When config bit 0 is 0, a started transfer reads device addresses 0 to count-1 in order, at most one per cycle. It drives config bits [26:24] on `dev_cs`. Host pops return the bytes in the order they were read.
- R3: Status bits [30:24] give the FIFO fill level and bits [15:0] the device transfers still to do. The fill level never exceeds the 64-byte depth.
- R4: When no device transfers remain and the FIFO is empty, the run-control bit clears by itself and status bit 31 (done) is set.
- R5: In read mode no device read is issued while the FIFO is full. In write mode no device write is issued while the FIFO is empty. In both cases the transfer resumes when space or data appears.
- R6: When config bit 0 is 1, host pushes are written to device addresses 0 to count-1 in push order. Pushes beyond the programmed count are ignored and do not reach the device.
- R7: While run control is nonzero, writes to config or count are refused. `refused` is high in the cycle after the write and the stored value is kept. A write of 1 to run control is refused while running or while config bit 7 (enable) is 0. A write of 0 to run control while running is also refused.
- R8: When config bit 2 is 1, `dma_req` is high while running and one of these holds. In read mode, the fill level is at or above the threshold in config bits [14:8], or no device transfers remain and the FIFO is not empty. In write mode, the free space is at or above the threshold and pushed bytes are still owed.
- R9: A write to address 4 whose bits [2:0] equal config bits [26:24] stops the engine, clears run control and config to 0, and empties the FIFO. Any other value is refused and changes nothing.
- R10: When config bit 2 is 0, `dma_req` stays low. The same threshold condition is reported in status bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| refused | output | 1 | Pulse: previous register write was rejected |
| host_push | input | 1 | Host pushes a byte (write mode) |
| host_wbyte | input | 8 | Byte pushed by the host |
| host_pop | input | 1 | Host pops a byte (read mode) |
| host_rbyte | output | 8 | Byte at the FIFO head |
| dma_req | output | 1 | Transfer request to a DMA agent |
| dev_cs | output | 3 | Selected chip select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_addr | output | CNT_W | Device byte address |
| dev_wdata | output | 8 | Device write data |
| dev_rdata | input | 8 | Device read data, same cycle |

## Verification
A wrong remaining count shows within one cycle, either as a device address out of sequence or as a status word that does not match the accesses seen. A FIFO pointer error shows on the first pop or device write after it, as a byte out of order. A lost or stuck run bit shows as a missing completion flag, or as accesses after completion. A faulty ownership compare shows on the stop write itself, because the `refused` pulse and the run-control readback disagree with the chip select written. Request-line faults show as soon as the fill level crosses the programmed threshold.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
   localparam logic [2:0] RA_CFG    = 3'd0;
   localparam logic [2:0] RA_COUNT  = 3'd1;
   localparam logic [2:0] RA_CTRL   = 3'd2;
   localparam logic [2:0] RA_STATUS = 3'd3;
   localparam logic [2:0] RA_STOP   = 3'd4;

   localparam int CS_W    = 3;
   localparam int CS_LSB  = 24;
   localparam int THR_LSB = 8;
   localparam int EN_BIT  = 7;
   localparam int DMA_BIT = 2;
   localparam int DIR_BIT = 0;

   localparam int ST_DONE = 31;
   localparam int ST_FILL = 24;
   localparam int ST_HIT  = 23;
endpackage

// File: rtl/pfe_fifo.sv
module pfe_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int FW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [FW-1:0] fill,
   output logic          full,
   output logic          empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pfe_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (fill == FW'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else if (flush) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
   import pfe_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int FW      = 7,
   parameter int DEF_THR = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic             idle,
   output logic [31:0]      cfg,
   output logic [CNT_W-1:0] count,
   output logic             run,
   output logic             done,
   output logic             refused,
   output logic             start,
   output logic             stop
);
   localparam logic [31:0] CFG_MASK = (32'(2**CS_W - 1) << CS_LSB)
                                    | (32'(2**FW - 1) << THR_LSB)
                                    | (32'd1 << EN_BIT)
                                    | (32'd1 << DMA_BIT)
                                    | (32'd1 << DIR_BIT);
   localparam logic [31:0] CFG_RST  = 32'(DEF_THR) << THR_LSB;

   logic wr_cfg, wr_cnt, wr_ctl, wr_stop, cs_match, refuse_now;

   assign wr_cfg   = reg_wr && (reg_addr == RA_CFG);
   assign wr_cnt   = reg_wr && (reg_addr == RA_COUNT);
   assign wr_ctl   = reg_wr && (reg_addr == RA_CTRL);
   assign wr_stop  = reg_wr && (reg_addr == RA_STOP);
   assign cs_match = (reg_wdata[CS_W-1:0] == cfg[CS_LSB +: CS_W]);

   assign start = wr_ctl && reg_wdata[0] && !run && cfg[EN_BIT];
   assign stop  = wr_stop && cs_match;

   assign refuse_now = ((wr_cfg || wr_cnt) && run)
                     || (wr_ctl && !start && (run || reg_wdata[0]))
                     || (wr_stop && !cs_match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= CFG_RST;
         count   <= '0;
         run     <= 1'b0;
         done    <= 1'b0;
         refused <= 1'b0;
      end else begin
         refused <= refuse_now;
         if (stop) begin
            run  <= 1'b0;
            done <= 1'b0;
            cfg  <= '0;
         end else if (start) begin
            run  <= 1'b1;
            done <= 1'b0;
         end else if (run && idle) begin
            run  <= 1'b0;
            done <= 1'b1;
         end
         if (wr_cfg && !run) cfg   <= reg_wdata & CFG_MASK;
         if (wr_cnt && !run) count <= reg_wdata[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/pfe_xfer.sv
module pfe_xfer #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 16,
   localparam int FW   = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic             clear,
   input  logic             dir,
   input  logic             dma,
   input  logic [FW-1:0]    thr,
   input  logic [FW-1:0]    fill,
   input  logic             full,
   input  logic             empty,
   input  logic [CNT_W-1:0] count,
   input  logic [7:0]       fifo_dout,
   input  logic [7:0]       dev_rdata,
   input  logic [7:0]       host_wbyte,
   input  logic             host_push,
   input  logic             host_pop,
   output logic             dev_rd,
   output logic             dev_wr,
   output logic [CNT_W-1:0] dev_addr,
   output logic [CNT_W-1:0] remaining,
   output logic [7:0]       dev_wdata,
   output logic [7:0]       f_din,
   output logic             f_push,
   output logic             f_pop,
   output logic             hit,
   output logic             dma_req,
   output logic             idle
);
   logic [CNT_W-1:0] owed;
   logic [FW-1:0]    free_sp;
   logic             access, push_ok, rd_hit, wr_hit;

   assign access    = run && (remaining != '0) && (dir ? !empty : !full);
   assign dev_rd    = access && !dir;
   assign dev_wr    = access && dir;
   assign dev_addr  = count - remaining;
   assign dev_wdata = fifo_dout;

   assign push_ok = run && dir && host_push && (owed != '0) && !full;
   assign f_push  = dir ? push_ok : dev_rd;
   assign f_din   = dir ? host_wbyte : dev_rdata;
   assign f_pop   = dir ? dev_wr : (run && host_pop && !empty);

   assign free_sp = FW'(DEPTH) - fill;
   assign rd_hit  = (fill >= thr) || ((remaining == '0) && !empty);
   assign wr_hit  = (free_sp >= thr) && (owed != '0);
   assign hit     = run && (dir ? wr_hit : rd_hit);
   assign dma_req = hit && dma;
   assign idle    = (remaining == '0) && empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         owed      <= '0;
      end else if (clear) begin
         remaining <= '0;
         owed      <= '0;
      end else if (load) begin
         remaining <= count;
         owed      <= count;
      end else begin
         if (access)  remaining <= remaining - 1'b1;
         if (push_ok) owed      <= owed - 1'b1;
      end
   end
endmodule

// File: rtl/pfe_engine.sv
module pfe_engine
   import pfe_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int CNT_W   = 16,
   parameter int DEF_THR = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             refused,
   input  logic             host_push,
   input  logic [7:0]       host_wbyte,
   input  logic             host_pop,
   output logic [7:0]       host_rbyte,
   output logic             dma_req,
   output logic [2:0]       dev_cs,
   output logic             dev_rd,
   output logic             dev_wr,
   output logic [CNT_W-1:0] dev_addr,
   output logic [7:0]       dev_wdata,
   input  logic [7:0]       dev_rdata
);
   localparam int FW = $clog2(DEPTH) + 1;

   if (CNT_W > 16 || CNT_W < 1) begin : g_bad_cnt
      $error("pfe_engine: CNT_W must be 1..16");
   end
   if (FW > 7) begin : g_bad_depth
      $error("pfe_engine: DEPTH must not exceed 64");
   end
   if (DEF_THR > DEPTH) begin : g_bad_thr
      $error("pfe_engine: DEF_THR must not exceed DEPTH");
   end

   logic [31:0]      cfg;
   logic [CNT_W-1:0] count, remaining;
   logic             run_w, done_w, start_w, stop_w, idle_w, hit_w;
   logic [FW-1:0]    fill_w;
   logic             full_w, empty_w, f_push, f_pop;
   logic [7:0]       f_din, f_dout;

   pfe_ctrl #(.CNT_W(CNT_W), .FW(FW), .DEF_THR(DEF_THR)) ctrl_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
      .idle(idle_w), .cfg, .count, .run(run_w), .done(done_w),
      .refused, .start(start_w), .stop(stop_w)
   );

   pfe_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
      .clk, .rst_n, .flush(start_w || stop_w), .push(f_push), .din(f_din),
      .pop(f_pop), .dout(f_dout), .fill(fill_w), .full(full_w), .empty(empty_w)
   );

   pfe_xfer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) xfer_i (
      .clk, .rst_n, .run(run_w), .load(start_w), .clear(stop_w),
      .dir(cfg[DIR_BIT]), .dma(cfg[DMA_BIT]), .thr(cfg[THR_LSB +: FW]),
      .fill(fill_w), .full(full_w), .empty(empty_w), .count,
      .fifo_dout(f_dout), .dev_rdata, .host_wbyte, .host_push, .host_pop,
      .dev_rd, .dev_wr, .dev_addr, .remaining, .dev_wdata, .f_din,
      .f_push, .f_pop, .hit(hit_w), .dma_req, .idle(idle_w)
   );

   assign dev_cs     = cfg[CS_LSB +: CS_W];
   assign host_rbyte = f_dout;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CFG:    reg_rdata = cfg;
         RA_COUNT:  reg_rdata[CNT_W-1:0] = count;
         RA_CTRL:   reg_rdata[0] = run_w;
         RA_STATUS: begin
            reg_rdata[ST_DONE]         = done_w;
            reg_rdata[ST_FILL +: FW]   = fill_w;
            reg_rdata[ST_HIT]          = hit_w;
            reg_rdata[CNT_W-1:0]       = remaining;
         end
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pfe_engine_chk.sv
module pfe_engine_chk
   import pfe_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = 16,
   localparam int FW   = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             done,
   input logic             dev_rd,
   input logic             dev_wr,
   input logic             dma_req,
   input logic             refused,
   input logic             reg_wr,
   input logic [2:0]       reg_addr,
   input logic [FW-1:0]    fill,
   input logic [CNT_W-1:0] remaining
);
   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));
   // R5
   rd_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd |-> fill != FW'(DEPTH));
   // R5
   wr_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr |-> fill != '0);
   // R2
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr));
   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!run && remaining == '0 && fill == '0));
   // R8
   req_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> run);
   // R7
   busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && run && (reg_addr == RA_CFG || reg_addr == RA_COUNT)) |=> refused);
   // R3
   rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd || dev_wr) |=> (remaining == $past(remaining) - 1'b1 || remaining == '0));
endmodule

bind pfe_engine pfe_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(run_w), .done(done_w), .dev_rd(dev_rd),
   .dev_wr(dev_wr), .dma_req(dma_req), .refused(refused), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .fill(fill_w), .remaining(remaining)
);

// File: tb/pfe_engine_tb.sv
module pfe_engine_tb_top;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic             refused;
   logic             host_push = 1'b0;
   logic [7:0]       host_wbyte = '0;
   logic             host_pop = 1'b0;
   logic [7:0]       host_rbyte;
   logic             dma_req;
   logic [2:0]       dev_cs;
   logic             dev_rd, dev_wr;
   logic [CNT_W-1:0] dev_addr;
   logic [7:0]       dev_wdata, dev_rdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 1'b0;

   always #5 clk = ~clk;

   pfe_engine dut_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .refused,
      .host_push, .host_wbyte, .host_pop, .host_rbyte, .dma_req,
      .dev_cs, .dev_rd, .dev_wr, .dev_addr, .dev_wdata, .dev_rdata
   );

   function automatic logic [7:0] pat(input int cs, input int a);
      return 8'(cs * 37 + a * 5 + 1);
   endfunction

   logic [7:0] mem [2048];
   assign dev_rdata = mem[{dev_cs, dev_addr[7:0]}];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2048; i++) mem[i] <= pat(i / 256, i % 256);
      end else if (dev_wr) begin
         mem[{dev_cs, dev_addr[7:0]}] <= dev_wdata;
      end
   end

   task automatic finish_run;
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         fails++;
         $display("FAIL watchdog (all R) act=timeout exp=completion");
         finish_run();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d, output logic rf);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      rf = refused;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      reg_read(3'd0, v); chk("R1 cfg default", v, 32'h0000_4000);
      reg_read(3'd2, v); chk("R1 ctrl", v, 0);
      reg_read(3'd3, v); chk("R1 status", v, 0);
      chk("R1 dma_req", 32'(dma_req), 0);
      chk("R1 no access", 32'({dev_rd, dev_wr}), 0);
   endtask

   task automatic t_read_small;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0200_0484, rf);
      reg_write(3'd1, 32'd10, rf);
      reg_write(3'd2, 32'd1, rf); chk("R2 start accepted", 32'(rf), 0);
      idle(15);
      reg_read(3'd3, v);
      chk("R3 fill after prefetch", 32'(v[30:24]), 10);
      chk("R3 remaining zero", 32'(v[15:0]), 0);
      chk("R8 req at threshold", 32'(dma_req), 1);
      for (int i = 0; i < 10; i++) begin
         chk("R2 read byte order", 32'(host_rbyte), 32'(pat(2, i)));
         if (i == 7) chk("R8 tail request below threshold", 32'(dma_req), 1);
         host_pop = 1'b1;
         @(negedge clk);
      end
      host_pop = 1'b0;
      idle(2);
      reg_read(3'd2, v); chk("R4 ctrl self-clear", v, 0);
      reg_read(3'd3, v); chk("R4 done flag", 32'(v[31]), 1);
      chk("R8 req off after done", 32'(dma_req), 0);
   endtask

   task automatic t_read_pause;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0100_4084, rf);
      reg_write(3'd1, 32'd80, rf);
      reg_write(3'd2, 32'd1, rf);
      idle(100);
      reg_read(3'd3, v);
      chk("R5 fill held at depth", 32'(v[30:24]), 64);
      chk("R5 remaining while paused", 32'(v[15:0]), 16);
      chk("R5 no read when full", 32'(dev_rd), 0);
      for (int i = 0; i < 80; i++) begin
         chk("R5 resumed byte order", 32'(host_rbyte), 32'(pat(1, i)));
         host_pop = 1'b1;
         @(negedge clk);
      end
      host_pop = 1'b0;
      idle(2);
      reg_read(3'd3, v); chk("R4 done after long read", 32'(v[31]), 1);
   endtask

   task automatic t_write_post;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0500_0885, rf);
      reg_write(3'd1, 32'd6, rf);
      reg_write(3'd2, 32'd1, rf);
      chk("R8 write request free space", 32'(dma_req), 1);
      for (int i = 0; i < 7; i++) begin
         host_push = 1'b1; host_wbyte = 8'(8'hA0 + i);
         @(negedge clk);
      end
      host_push = 1'b0;
      idle(10);
      for (int i = 0; i < 6; i++)
         chk("R6 device byte", 32'(mem[5 * 256 + i]), 32'(8'hA0 + i));
      chk("R6 extra push ignored", 32'(mem[5 * 256 + 6]), 32'(pat(5, 6)));
      reg_read(3'd3, v);
      chk("R4 write done", 32'(v[31]), 1);
      chk("R3 write fill drained", 32'(v[30:24]), 0);
   endtask

   task automatic t_busy_stop;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0300_4084, rf);
      reg_write(3'd1, 32'd100, rf);
      reg_write(3'd2, 32'd1, rf);
      reg_write(3'd0, 32'h0, rf); chk("R7 cfg refused", 32'(rf), 1);
      reg_read(3'd0, v); chk("R7 cfg kept", v, 32'h0300_4084);
      reg_write(3'd1, 32'd5, rf); chk("R7 count refused", 32'(rf), 1);
      reg_read(3'd1, v); chk("R7 count kept", v, 100);
      reg_write(3'd2, 32'd1, rf); chk("R7 restart refused", 32'(rf), 1);
      reg_write(3'd2, 32'd0, rf); chk("R7 clear refused", 32'(rf), 1);
      reg_write(3'd4, 32'd6, rf); chk("R9 foreign stop refused", 32'(rf), 1);
      reg_read(3'd2, v); chk("R9 still running", v, 1);
      reg_write(3'd4, 32'd3, rf); chk("R9 owner stop accepted", 32'(rf), 0);
      reg_read(3'd2, v); chk("R9 ctrl cleared", v, 0);
      reg_read(3'd0, v); chk("R9 cfg cleared", v, 0);
      reg_read(3'd3, v); chk("R9 fifo flushed", v, 0);
   endtask

   task automatic t_no_enable;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0000_0400, rf);
      reg_write(3'd1, 32'd3, rf);
      reg_write(3'd2, 32'd1, rf); chk("R7 start without enable refused", 32'(rf), 1);
      idle(5);
      reg_read(3'd2, v); chk("R7 ctrl stays idle", v, 0);
      reg_read(3'd3, v); chk("R7 no transfer", v, 0);
   endtask

   task automatic t_polling;
      logic rf; logic [31:0] v;
      reg_write(3'd0, 32'h0400_0280, rf);
      reg_write(3'd1, 32'd5, rf);
      reg_write(3'd2, 32'd1, rf);
      idle(10);
      chk("R10 no dma request", 32'(dma_req), 0);
      reg_read(3'd3, v);
      chk("R10 status hit", 32'(v[23]), 1);
      chk("R10 fill", 32'(v[30:24]), 5);
      reg_write(3'd4, 32'd4, rf);
      reg_read(3'd3, v); chk("R9 flush by stop", v, 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_read_small();
      t_read_pause();
      t_write_post();
      t_busy_stop();
      t_no_enable();
      t_polling();
      finish_run();
   end
endmodule